// File: doc/BRIEF.md
# Prioritized External Interrupt Level Arbiter

The arbiter watches fifteen external interrupt level lines and keeps one registered pending trap index for a processor core. When the slot is free, or already holds an external interrupt, the highest active level wins. Its number is tagged into an external-interrupt trap type, and a single hard-interrupt request line is raised toward the core. A pending trap of any other kind cannot be displaced by interrupts. When every level line drops while an interrupt is pending, the slot empties and the request falls.

The core loads non-interrupt traps through a write port with a strobe, and it returns an acknowledge pulse when it takes the pending trap. The acknowledge empties the slot, and the level lines are looked at again on the following cycle. The controller is a three-state machine. In `ARB_IDLE` the slot is empty. In `ARB_EXT` it holds an external-interrupt index. In `ARB_TRAP` it holds a non-interrupt index. The transitions are named as follows:
- IDLE->EXT (levels appear)
- EXT->EXT (retag to a new winner)
- EXT->IDLE (levels all drop, or acknowledge)
- any->TRAP (write of a non-interrupt index)
- TRAP->TRAP (hold)
- TRAP->IDLE (acknowledge)
- any->IDLE or any->EXT (write of zero, or write of an interrupt-class index)

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, `pend_idx_o` is 0 and `hard_req_o` is 0.
- R2: Line `irq_lvl_i[k]` stands for level k (1..15), and the highest active level wins. The index stored is 0x10 ORed with the winning level, which gives a value from 0x11 to 0x1F.
- R3: A level winner is recorded only when the stored index is 0, or when its bits 7:4 equal 0x1.
- R4: `hard_req_o` is set when a recorded winner's index differs from the stored index. If the index is unchanged, `hard_req_o` keeps its previous value.
- R5: If all level lines are 0 while the stored index has bits 7:4 equal to 0x1, the next clock clears the index to 0 and `hard_req_o` to 0.
- R6: A stored nonzero index whose bits 7:4 are not 0x1 stays unchanged whatever the level lines do, until it is written or acknowledged.
- R7: `trap_wr_i` loads `trap_idx_i` into the stored index and clears `hard_req_o`. It takes priority over level evaluation in the same cycle.
- R8: `trap_ack_i` clears the index and `hard_req_o` on the next clock. It takes priority over a write and over the level lines in the same cycle, and the cycle after it evaluates the levels again.
- R9: Both outputs are registered. They change only at the clock edge that follows a change of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lvl_i | input | 15 | Pending levels, bit k = level k (bits 15..1) |
| trap_wr_i | input | 1 | Load strobe for a non-interrupt trap index |
| trap_idx_i | input | 8 | Trap index to load |
| trap_ack_i | input | 1 | Core has taken the pending trap |
| pend_idx_o | output | 8 | Registered pending trap index |
| hard_req_o | output | 1 | Registered hard-interrupt request |

## Verification
The acknowledge and a level re-evaluation can fall in the same cycle, as can a trap write and a level change. The bench provokes these collisions in directed steps. In the random phase it drives acknowledge, write and levels independently, so the collisions also happen there. Each result is judged against a bench model that applies the priority order acknowledge, then write, then levels. The cycle after an acknowledge is checked to show that held levels are picked up again and the request is raised afresh.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_EXT  = 2'd1,
        ARB_TRAP = 2'd2
    } arb_state_t;

endpackage

// File: rtl/irqarb_prio_enc.sv
module irqarb_prio_enc #(
    parameter int LEVELS = 15,
    parameter int LVL_W  = $clog2(LEVELS + 1)
) (
    input  logic [LEVELS:1]   lvl_i,
    output logic              any_o,
    output logic [LVL_W-1:0]  top_o
);

    logic [LVL_W-1:0] win [LEVELS+1];

    assign win[0] = '0;

    // Chain from level 1 upward: a higher active level overrides a lower one.
    for (genvar k = 1; k <= LEVELS; k++) begin : g_chain
        assign win[k] = lvl_i[k] ? LVL_W'(k) : win[k-1];
    end

    assign top_o = win[LEVELS];
    assign any_o = |lvl_i;

endmodule

// File: rtl/irqarb_tagger.sv
module irqarb_tagger #(
    parameter int              LVL_W    = 4,
    parameter int              IDX_W    = 8,
    parameter logic [IDX_W-1:0] EXT_BASE = 8'h10
) (
    input  logic [LVL_W-1:0] top_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] cand_o,
    output logic             is_ext_o
);

    localparam int HI_W = IDX_W - LVL_W;

    assign cand_o   = EXT_BASE | {{HI_W{1'b0}}, top_i};
    assign is_ext_o = (idx_i[IDX_W-1:LVL_W] == EXT_BASE[IDX_W-1:LVL_W]);

endmodule

// File: rtl/irqarb_ctrl.sv
module irqarb_ctrl
    import irqarb_pkg::*;
#(
    parameter int LVL_W = 4,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_i,
    input  logic [IDX_W-1:0] cand_i,
    input  logic             wr_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_is_ext_i,
    input  logic             ack_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             req_o
);

    arb_state_t       st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             req_q, req_d;

    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        req_d = req_q;
        if (ack_i) begin
            st_d  = ARB_IDLE;
            idx_d = '0;
            req_d = 1'b0;
        end else if (wr_i) begin
            idx_d = wr_idx_i;
            req_d = 1'b0;
            if (wr_idx_i == '0) begin
                st_d = ARB_IDLE;
            end else if (wr_is_ext_i) begin
                st_d = ARB_EXT;
            end else begin
                st_d = ARB_TRAP;
            end
        end else begin
            unique case (st_q)
                ARB_IDLE: begin
                    if (any_i) begin
                        st_d  = ARB_EXT;
                        idx_d = cand_i;
                        req_d = 1'b1;
                    end
                end
                ARB_EXT: begin
                    if (any_i) begin
                        idx_d = cand_i;
                        if (cand_i != idx_q) begin
                            req_d = 1'b1;
                        end
                    end else begin
                        st_d  = ARB_IDLE;
                        idx_d = '0;
                        req_d = 1'b0;
                    end
                end
                ARB_TRAP: begin
                    st_d = ARB_TRAP;
                end
                default: begin
                    st_d  = ARB_IDLE;
                    idx_d = '0;
                    req_d = 1'b0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ARB_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            req_q <= 1'b0;
        end else begin
            idx_q <= idx_d;
            req_q <= req_d;
        end
    end

    assign idx_o = idx_q;
    assign req_o = req_q;

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
    parameter int               LEVELS   = 15,
    parameter int               IDX_W    = 8,
    parameter logic [IDX_W-1:0] EXT_BASE = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS:1]   irq_lvl_i,
    input  logic              trap_wr_i,
    input  logic [IDX_W-1:0]  trap_idx_i,
    input  logic              trap_ack_i,
    output logic [IDX_W-1:0]  pend_idx_o,
    output logic              hard_req_o
);

    localparam int LVL_W = $clog2(LEVELS + 1);

    logic             any_lvl;
    logic [LVL_W-1:0] top_lvl;
    logic [IDX_W-1:0] cand;
    logic             cur_is_ext;
    logic [IDX_W-1:0] wr_cand_unused;
    logic             wr_is_ext;

    irqarb_prio_enc #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_enc (
        .lvl_i (irq_lvl_i),
        .any_o (any_lvl),
        .top_o (top_lvl)
    );

    irqarb_tagger #(.LVL_W(LVL_W), .IDX_W(IDX_W), .EXT_BASE(EXT_BASE)) u_tag (
        .top_i    (top_lvl),
        .idx_i    (pend_idx_o),
        .cand_o   (cand),
        .is_ext_o (cur_is_ext)
    );

    irqarb_tagger #(.LVL_W(LVL_W), .IDX_W(IDX_W), .EXT_BASE(EXT_BASE)) u_wtag (
        .top_i    (top_lvl),
        .idx_i    (trap_idx_i),
        .cand_o   (wr_cand_unused),
        .is_ext_o (wr_is_ext)
    );

    irqarb_ctrl #(.LVL_W(LVL_W), .IDX_W(IDX_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_i       (any_lvl),
        .cand_i      (cand),
        .wr_i        (trap_wr_i),
        .wr_idx_i    (trap_idx_i),
        .wr_is_ext_i (wr_is_ext),
        .ack_i       (trap_ack_i),
        .idx_o       (pend_idx_o),
        .req_o       (hard_req_o)
    );

    logic unused_ok;
    assign unused_ok = cur_is_ext ^ (|wr_cand_unused);

endmodule

// File: rtl/irqarb_chk.sv
module irqarb_chk #(
    parameter int               LEVELS   = 15,
    parameter int               IDX_W    = 8,
    parameter logic [IDX_W-1:0] EXT_BASE = 8'h10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LEVELS:1]   irq_lvl_i,
    input logic              trap_wr_i,
    input logic [IDX_W-1:0]  trap_idx_i,
    input logic              trap_ack_i,
    input logic [IDX_W-1:0]  pend_idx_o,
    input logic              hard_req_o
);

    localparam int LVL_W = $clog2(LEVELS + 1);

    logic idx_ext;
    assign idx_ext = (pend_idx_o[IDX_W-1:LVL_W] == EXT_BASE[IDX_W-1:LVL_W]);

    // R8: acknowledge empties the slot and drops the request
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ack_i |=> (pend_idx_o == '0) && !hard_req_o);

    // R7: write loads the index and drops the request
    p_write_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_wr_i && !trap_ack_i) |=> (pend_idx_o == $past(trap_idx_i)) && !hard_req_o);

    // R5: all levels low with an interrupt pending clears the slot
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_ack_i && !trap_wr_i && (irq_lvl_i == '0) && idx_ext)
        |=> (pend_idx_o == '0) && !hard_req_o);

    // R6: a non-interrupt trap is not displaced by levels
    p_trap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_ack_i && !trap_wr_i && (pend_idx_o != '0) && !idx_ext)
        |=> $stable(pend_idx_o));

    // R4: the request only rises together with a changed index
    p_rise_on_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hard_req_o) |-> (pend_idx_o != $past(pend_idx_o)) && idx_ext);

    // R2: a raised request always points at an interrupt index with a level
    p_req_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hard_req_o |-> idx_ext);

endmodule

bind irq_level_arbiter irqarb_chk #(
    .LEVELS   (LEVELS),
    .IDX_W    (IDX_W),
    .EXT_BASE (EXT_BASE)
) chk_i (.*);

// File: tb/irq_level_arbiter_tb_top.sv
module irq_level_arbiter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:1] lvl = '0;
    logic        wr = 1'b0;
    logic [7:0]  widx = '0;
    logic        ack = 1'b0;
    logic [7:0]  idx;
    logic        req;

    int total = 0;
    int bad = 0;
    logic [7:0] m_idx = '0;
    logic       m_req = 1'b0;

    always #2 clk = ~clk;

    irq_level_arbiter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_lvl_i  (lvl),
        .trap_wr_i  (wr),
        .trap_idx_i (widx),
        .trap_ack_i (ack),
        .pend_idx_o (idx),
        .hard_req_o (req)
    );

    function automatic logic [7:0] winner(input logic [15:1] l);
        logic [7:0] t = 8'h00;
        for (int k = 1; k <= 15; k++) if (l[k]) t = 8'h10 | 8'(k);
        return t;
    endfunction

    function automatic logic is_ext(input logic [7:0] v);
        return v[7:4] == 4'h1;
    endfunction

    task automatic model_step();
        logic [7:0] c;
        if (ack) begin
            m_idx = '0; m_req = 1'b0;
        end else if (wr) begin
            m_idx = widx; m_req = 1'b0;
        end else if (lvl != '0 && (m_idx == '0 || is_ext(m_idx))) begin
            c = winner(lvl);
            if (c != m_idx) m_req = 1'b1;
            m_idx = c;
        end else if (lvl == '0 && is_ext(m_idx)) begin
            m_idx = '0; m_req = 1'b0;
        end
    endtask

    task automatic check(input string tag);
        total++;
        if (idx !== m_idx || req !== m_req) begin
            bad++;
            $display("FAIL %s: idx=%h req=%b expected idx=%h req=%b", tag, idx, req, m_idx, m_req);
        end
    endtask

    task automatic step(input logic [15:1] l, input logic w, input logic [7:0] wi,
                        input logic a, input string tag);
        lvl = l; wr = w; widx = wi; ack = a;
        #1 check("R9 pre-edge");
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        step(15'h0004, 0, 8'h00, 0, "R2 single level 3");
        step(15'h0104, 0, 8'h00, 0, "R2 R4 levels 3 and 9");
        step(15'h4001, 0, 8'h00, 0, "R2 levels 15 and 1");
        step(15'h4001, 0, 8'h00, 0, "R4 same winner holds");
        step(15'h0000, 0, 8'h00, 0, "R5 all levels drop");
        step(15'h0000, 0, 8'h00, 0, "R5 stays idle");
        step(15'h0000, 1, 8'h15, 0, "R7 write interrupt-class index");
        step(15'h0010, 0, 8'h00, 0, "R4 equal winner no raise");
        step(15'h0080, 0, 8'h00, 0, "R3 R4 retag raises");
        step(15'h0080, 1, 8'h09, 0, "R7 write beats levels");
        step(15'h7FFF, 0, 8'h00, 0, "R6 R3 trap not displaced");
        step(15'h0000, 0, 8'h00, 0, "R6 trap survives zero levels");
        step(15'h0002, 0, 8'h00, 1, "R8 ack beats levels");
        step(15'h0002, 0, 8'h00, 0, "R8 re-evaluate after ack");
        step(15'h0002, 1, 8'h2A, 1, "R8 ack beats write");
        step(15'h0000, 1, 8'h00, 0, "R7 write zero");

        for (int i = 0; i < 400; i++) begin
            logic [15:1] l;
            logic [7:0]  wi;
            r = $urandom();
            unique case (r[1:0])
                2'd0:    l = '0;
                2'd1:    l = 15'(1) << r[5:2] % 15;
                default: l = r[30:16];
            endcase
            wi = r[9] ? {r[14:12], 1'b0, r[20:17]} : 8'h00;
            step(l, r[7:6] == 2'b11, wi, r[11:10] == 2'b11, "R2-mix random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule